// File: doc/BRIEF.md
# Handshake Latch-Controller Pipeline FIFO

This block is a first-in first-out buffer made of a chain of latch stages. No shared enable moves data from stage to stage. Each stage's controller drives the stage's data latch, and it does so only from four-phase return-to-zero request/acknowledge exchanges with the two neighbouring stages. A producer pushes words in through an input channel (request, acknowledge, data). A consumer takes words from an output channel of the same kind. Each bit of the occupancy vector shows whether that stage's latch is closed on a valid word.

Two controller styles are available, chosen by a parameter. The decoupled style uses an internal state bit, so a stage can accept a new word while its output request is still settling, and every stage can hold a word. The coupled style is a single C-element of the incoming request and the inverted outgoing acknowledge, and it can keep a word only in every other stage. Every state-holding gate is emulated as a register that updates on a fast sampling clock, so the block maps onto ordinary flip-flops.

Top module: `hs_latch_fifo`

## Requirements
- R1: After synchronous reset every stage is empty: occupancy is all zero, and in_ack and out_req are low.
- R2: in_ack rises only while in_req is high, and it falls only while in_req is low.
- R3: Once out_req is high, it stays high and out_data stays unchanged until out_ack has risen. out_req falls only after out_ack has been seen high.
- R4: Words leave through the output channel in the order they were accepted, with none lost and none repeated.
- R5: In decoupled mode (KIND = CTRL_SEMI), a producer that is always ready and a consumer that never acknowledges lead to a stall after exactly STAGES words are accepted, with occupancy all ones. Occupancy bit i belongs to stage i, and stage 0 is next to the input.
- R6: In coupled mode (KIND = CTRL_SIMPLE), the same stall comes after STAGES/2 words for an even STAGES. Only the odd-indexed stages are occupied (6'b101010 for six stages), in_req is left high and in_ack low.
- R7: In decoupled mode, a stage's input acknowledge returns to zero only after its output acknowledge has been seen high. In the full stall this means in_ack stays high after in_req has fallen.
- R8: When the stalled pipeline is drained, occupancy returns to all zero and out_req and in_ack go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that updates the emulated state-holding gates |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Request on the input push channel |
| in_ack | output | 1 | Acknowledge on the input push channel |
| in_data | input | WIDTH | Word offered on the input channel |
| out_req | output | 1 | Request on the output push channel |
| out_ack | input | 1 | Acknowledge on the output push channel |
| out_data | output | WIDTH | Word presented on the output channel |
| occupancy | output | STAGES | One bit per stage, set while that stage's latch holds a word |

## Verification
The bench builds two six-stage, 8-bit instances side by side, one for each controller style. Both therefore run the same stimulus, and their stall states can be compared directly. Six stages is an even depth, so the coupled style's alternating pattern ends cleanly at three words. The same depth is deep enough that the decoupled style's fully packed pipeline differs clearly from it. In the stall, the two styles also leave the input handshake in different phases. Streaming runs with an irregular consumer delay check ordering in both styles.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    CTRL_SEMI   = 1'b0,
    CTRL_SIMPLE = 1'b1
  } ctrl_kind_e;
endpackage

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl #(
  parameter hs_pkg::ctrl_kind_e KIND = hs_pkg::CTRL_SEMI
) (
  input  logic clk,
  input  logic rst,
  input  logic ri,
  input  logic ao,
  output logic ro,
  output logic ai,
  output logic hold
);
  generate
    if (KIND == hs_pkg::CTRL_SEMI) begin : g_semi
      logic st_q;
      logic ro_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          st_q <= 1'b0;
          ro_q <= 1'b0;
        end else begin
          if (ri && !ro_q)            st_q <= 1'b1;
          else if (!ri && ro_q && ao) st_q <= 1'b0;
          if (st_q && !ao)            ro_q <= 1'b1;
          else if (!st_q)             ro_q <= 1'b0;
        end
      end
      assign ro   = ro_q;
      assign ai   = st_q;
      assign hold = st_q;

      // R7: input-side return to zero waits for the downstream acknowledge
      assert_ack_rtz_after_ao_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q) |-> $past(ao));
    end else begin : g_simple
      logic c_q;
      always_ff @(posedge clk) begin
        if (rst)             c_q <= 1'b0;
        else if (ri && !ao)  c_q <= 1'b1;
        else if (!ri && ao)  c_q <= 1'b0;
      end
      assign ro   = c_q;
      assign ai   = c_q;
      assign hold = c_q;
    end
  endgenerate

  // R2: acknowledge follows the request phase
  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ai) |-> $past(ri));
  assert_ack_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ai) |-> !$past(ri));
  // R3: outgoing request withdrawn only after the acknowledge
  assert_req_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ro) |-> $past(ao));
endmodule

// File: rtl/hs_data_latch.sv
module hs_data_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // transparent while hold is low, opaque while hold is high
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/hs_stage.sv
module hs_stage #(
  parameter int                 WIDTH = 8,
  parameter hs_pkg::ctrl_kind_e KIND  = hs_pkg::CTRL_SEMI
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ri,
  output logic             ai,
  input  logic [WIDTH-1:0] di,
  output logic             ro,
  input  logic             ao,
  output logic [WIDTH-1:0] dq,
  output logic             full
);
  logic hold;

  hs_stage_ctrl #(.KIND(KIND)) u_ctrl (
    .clk(clk), .rst(rst), .ri(ri), .ao(ao), .ro(ro), .ai(ai), .hold(hold)
  );

  hs_data_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .hold(hold), .d(di), .q(dq)
  );

  assign full = hold;
endmodule

// File: rtl/hs_latch_fifo.sv
module hs_latch_fifo #(
  parameter int                 STAGES = 6,
  parameter int                 WIDTH  = 8,
  parameter hs_pkg::ctrl_kind_e KIND   = hs_pkg::CTRL_SEMI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [WIDTH-1:0]  in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [WIDTH-1:0]  out_data,
  output logic [STAGES-1:0] occupancy
);
  localparam int LINKS = STAGES + 1;

  logic [LINKS-1:0] req_c;
  logic [LINKS-1:0] ack_c;
  logic [WIDTH-1:0] dat_c [LINKS];

  assign req_c[0]      = in_req;
  assign dat_c[0]      = in_data;
  assign ack_c[STAGES] = out_ack;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    hs_stage #(.WIDTH(WIDTH), .KIND(KIND)) u_stage (
      .clk (clk),
      .rst (rst),
      .ri  (req_c[i]),
      .ai  (ack_c[i]),
      .di  (dat_c[i]),
      .ro  (req_c[i+1]),
      .ao  (ack_c[i+1]),
      .dq  (dat_c[i+1]),
      .full(occupancy[i])
    );
  end

  assign in_ack   = ack_c[0];
  assign out_req  = req_c[STAGES];
  assign out_data = dat_c[STAGES];

  // R3: offered word stays put until the consumer acknowledges
  assert_out_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_ack && $past(out_req && !out_ack)) |-> $stable(out_data));
  // R3: offered request is not withdrawn before the acknowledge
  assert_out_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(out_req) && !$past(out_ack)) |-> out_req);
endmodule

// File: tb/hs_latch_fifo_test.sv
`timescale 1ns/1ps
module hs_latch_fifo_test;
  localparam int STAGES = 6;
  localparam int WIDTH  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              in_req_m   [2];
  logic              in_ack_m   [2];
  logic [WIDTH-1:0]  in_data_m  [2];
  logic              out_req_m  [2];
  logic              out_ack_m  [2];
  logic [WIDTH-1:0]  out_data_m [2];
  logic [STAGES-1:0] occ_m      [2];

  logic [WIDTH-1:0] tx_val [2];
  logic [WIDTH-1:0] rx_val [2];
  int accepted [2];
  int total = 0;
  int bad   = 0;
  bit finished = 0;

  hs_latch_fifo #(.STAGES(STAGES), .WIDTH(WIDTH), .KIND(hs_pkg::CTRL_SEMI)) uut (
    .clk(clk), .rst(rst),
    .in_req(in_req_m[0]), .in_ack(in_ack_m[0]), .in_data(in_data_m[0]),
    .out_req(out_req_m[0]), .out_ack(out_ack_m[0]), .out_data(out_data_m[0]),
    .occupancy(occ_m[0])
  );

  hs_latch_fifo #(.STAGES(STAGES), .WIDTH(WIDTH), .KIND(hs_pkg::CTRL_SIMPLE)) uut_c (
    .clk(clk), .rst(rst),
    .in_req(in_req_m[1]), .in_ack(in_ack_m[1]), .in_data(in_data_m[1]),
    .out_req(out_req_m[1]), .out_ack(out_ack_m[1]), .out_data(out_data_m[1]),
    .occupancy(occ_m[1])
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic producer(input int m, input int n);
    for (int k = 0; k < n; k++) begin
      while (in_ack_m[m]) @(negedge clk);
      in_data_m[m] = tx_val[m];
      tx_val[m]++;
      in_req_m[m] = 1'b1;
      do @(negedge clk); while (!in_ack_m[m]);
      in_req_m[m] = 1'b0;
      accepted[m]++;
    end
  endtask

  task automatic consumer(input int m, input int n, input bit vary);
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!out_req_m[m]);
      check(out_data_m[m] == rx_val[m], "R4 order", int'(out_data_m[m]), int'(rx_val[m]));
      rx_val[m]++;
      if (vary) repeat (k % 3) @(negedge clk);
      out_ack_m[m] = 1'b1;
      do @(negedge clk); while (out_req_m[m]);
      out_ack_m[m] = 1'b0;
    end
  endtask

  task automatic test_reset();
    for (int m = 0; m < 2; m++) begin
      check(occ_m[m] == '0, "R1 occupancy", int'(occ_m[m]), 0);
      check(in_ack_m[m] == 1'b0, "R1 in_ack", int'(in_ack_m[m]), 0);
      check(out_req_m[m] == 1'b0, "R1 out_req", int'(out_req_m[m]), 0);
    end
  endtask

  task automatic test_stall(input int m, input int exp_tok, input logic [STAGES-1:0] exp_occ,
                            input bit exp_req, input bit exp_ack, input string tag,
                            input string hs_tag);
    logic [WIDTH-1:0] first;
    accepted[m] = 0;
    first = tx_val[m];
    fork
      producer(m, STAGES + 2);
    join_none
    repeat (200) @(negedge clk);
    check(accepted[m] == exp_tok, {tag, " tokens"}, accepted[m], exp_tok);
    check(occ_m[m] == exp_occ, {tag, " occupancy"}, int'(occ_m[m]), int'(exp_occ));
    check(in_req_m[m] == exp_req, {hs_tag, " in_req"}, int'(in_req_m[m]), int'(exp_req));
    check(in_ack_m[m] == exp_ack, {hs_tag, " in_ack"}, int'(in_ack_m[m]), int'(exp_ack));
    check(out_req_m[m] == 1'b1, "R3 out_req held", int'(out_req_m[m]), 1);
    check(out_data_m[m] == first, "R3 out_data held", int'(out_data_m[m]), int'(first));
    consumer(m, STAGES + 2, 1'b0);
    wait fork;
    repeat (20) @(negedge clk);
    check(occ_m[m] == '0, "R8 drained occupancy", int'(occ_m[m]), 0);
    check(out_req_m[m] == 1'b0, "R8 out_req", int'(out_req_m[m]), 0);
    check(in_ack_m[m] == 1'b0, "R8 in_ack", int'(in_ack_m[m]), 0);
  endtask

  task automatic test_stream(input int m, input int n);
    fork
      producer(m, n);
      consumer(m, n, 1'b1);
    join
    repeat (20) @(negedge clk);
    check(occ_m[m] == '0, "R4 stream empty", int'(occ_m[m]), 0);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      in_req_m[m]  = 1'b0;
      in_data_m[m] = '0;
      out_ack_m[m] = 1'b0;
      tx_val[m]    = 8'h30 + 8'(m * 64);
      rx_val[m]    = 8'h30 + 8'(m * 64);
      accepted[m]  = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_stall(0, STAGES, {STAGES{1'b1}}, 1'b0, 1'b1, "R5 decoupled stall", "R7");
    test_stall(1, STAGES / 2, 6'b101010, 1'b1, 1'b0, "R6 coupled stall", "R2");
    test_stream(0, 24);
    test_stream(1, 24);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule